// File: doc/BRIEF.md
# Synchronized Ring Relay Controller

This block decides, for one subscriber line, when the ringing relay is energized. A line card controller requests ringing with an active-low command. A ring-sync clock is high around the zero crossing of the ring voltage, and the relay may only engage or release on that high level. This keeps relay contacts from switching while the ring voltage is large. If no alignment is wanted, the sync input is tied high and the command takes effect at once.

Two conditions veto ringing: an active-low power-denial input, and an active-low hook status that reads low when the set is off hook. If the subscriber answers while ringing, the relay is dropped right away (ring trip). The relay then stays released until the command is withdrawn. All four inputs are asynchronous and pass through multi-flop synchronizers. A small state machine tracks idle, armed (waiting for sync), ringing and tripped.

Top module: `ring_relay_ctrl`

## Requirements
- R1: While the synchronous active-high reset `rst` is sampled high, the controller returns to idle. On the clock edge after that, `relay_n` reads 1, which means released.
- R2: With the command active (`ring_cmd_n`=0) and `ring_sync`=0, `relay_n` stays 1 for as long as sync stays low.
- R3: Take a line that is armed, not vetoed and with the command active. When `ring_sync` goes high, `relay_n` goes to 0 exactly SYNC_STAGES+1 clock edges later. If `ring_sync` is already held high, the same delay counts from the command edge.
- R4: Power denial (`pwr_deny_n`=0) keeps `relay_n` at 1. If it is applied while ringing, the relay releases SYNC_STAGES+1 edges after the input edge, whatever the sync level. Once denial is removed, a command that is still active rings again.
- R5: If `hook_n`=0 (off hook) before the command arrives, the relay never engages.
- R6: If the line goes off hook while ringing, the relay releases SYNC_STAGES+1 edges after the hook edge (ring trip). It stays released while the command stays active, even after the line returns on hook.
- R7: Withdrawing the command clears a trip. A later command rings again.
- R8: Withdrawing the command while ringing does not release the relay while `ring_sync` is low. The release comes SYNC_STAGES+1 edges after sync next goes high.
- R9: If a veto (off hook or denial) and the sync high level reach an armed controller in the same cycle, the veto wins and the relay does not engage.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst | input | 1 | Synchronous reset, active high |
| ring_cmd_n | input | 1 | Ringing request, active low, asynchronous |
| ring_sync | input | 1 | Zero-crossing sync, high level permits relay changes, asynchronous |
| pwr_deny_n | input | 1 | Power denial, active low, asynchronous |
| hook_n | input | 1 | Hook status, low means off hook, asynchronous |
| relay_n | output | 1 | Ring relay drive, low means energized |

## Verification
The sync level and a veto can reach the state machine in the same cycle. In the armed state that is a race between engaging and dropping back to idle. The bench sets up this race by arming the line with sync low. It then moves sync high and, on the same falling clock edge, either takes the line off hook or applies power denial. The relay is sampled every cycle afterwards and must never read energized. A second collision also gets a directed check: a command that has been withdrawn waits while sync is low and must release on the edge where sync rises.

// File: rtl/ring_pkg.sv
package ring_pkg;

  typedef enum logic [1:0] {
    RS_IDLE    = 2'd0,
    RS_ARMED   = 2'd1,
    RS_RINGING = 2'd2,
    RS_TRIPPED = 2'd3
  } ring_state_t;

  // Either veto source blocks or drops the relay.
  function automatic logic f_veto(input logic deny, input logic offhook);
    return deny | offhook;
  endfunction

  // A request may start a ring cycle only when nothing vetoes it.
  function automatic logic f_may_start(input logic cmd, input logic deny,
                                       input logic offhook);
    return cmd & ~f_veto(deny, offhook);
  endfunction

  // A ringing relay may drop for command removal only on the sync level.
  function automatic logic f_may_stop(input logic cmd, input logic sync_hi);
    return ~cmd & sync_hi;
  endfunction

endpackage

// File: rtl/ring_sync_bank.sv
module ring_sync_bank #(
  parameter int          WIDTH   = 4,
  parameter int          STAGES  = 2,
  parameter logic [WIDTH-1:0] RST_VAL = '0
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] d_async,
  output logic [WIDTH-1:0] q_sync
);

  localparam int LAST = STAGES - 1;

  logic [WIDTH-1:0] pipe [STAGES];

  generate
    for (genvar s = 0; s < STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
        always_ff @(posedge clk) begin
          if (rst) pipe[s] <= RST_VAL;
          else     pipe[s] <= d_async;
        end
      end else begin : g_rest
        always_ff @(posedge clk) begin
          if (rst) pipe[s] <= RST_VAL;
          else     pipe[s] <= pipe[s-1];
        end
      end
    end
  endgenerate

  assign q_sync = pipe[LAST];

endmodule

// File: rtl/ring_qualify.sv
module ring_qualify
  import ring_pkg::*;
(
  input  logic cmd_n_s,
  input  logic sync_s,
  input  logic pd_n_s,
  input  logic hook_n_s,
  output logic cmd_act,
  output logic sync_hi,
  output logic deny,
  output logic offhook,
  output logic veto,
  output logic start_ok,
  output logic stop_ok
);

  always_comb begin
    cmd_act  = ~cmd_n_s;
    sync_hi  = sync_s;
    deny     = ~pd_n_s;
    offhook  = ~hook_n_s;
    veto     = f_veto(deny, offhook);
    start_ok = f_may_start(cmd_act, deny, offhook);
    stop_ok  = f_may_stop(cmd_act, sync_hi);
  end

endmodule

// File: rtl/ring_fsm.sv
module ring_fsm
  import ring_pkg::*;
(
  input  logic        clk,
  input  logic        rst,
  input  logic        cmd_act,
  input  logic        sync_hi,
  input  logic        deny,
  input  logic        offhook,
  input  logic        start_ok,
  input  logic        stop_ok,
  output ring_state_t state,
  output logic        relay_n,
  output logic        ev_engage,
  output logic        ev_trip,
  output logic        ev_release
);

  ring_state_t nxt;

  always_comb begin
    nxt = state;
    unique case (state)
      RS_IDLE: begin
        if (start_ok) nxt = sync_hi ? RS_RINGING : RS_ARMED;
      end
      RS_ARMED: begin
        if (!start_ok)    nxt = RS_IDLE;
        else if (sync_hi) nxt = RS_RINGING;
      end
      RS_RINGING: begin
        if (deny)         nxt = RS_IDLE;
        else if (offhook) nxt = RS_TRIPPED;
        else if (stop_ok) nxt = RS_IDLE;
      end
      RS_TRIPPED: begin
        if (!cmd_act) nxt = RS_IDLE;
      end
      default: nxt = RS_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state   <= RS_IDLE;
      relay_n <= 1'b1;
    end else begin
      state   <= nxt;
      relay_n <= (nxt != RS_RINGING);
    end
  end

  assign ev_engage  = (state != RS_RINGING) && (nxt == RS_RINGING);
  assign ev_trip    = (state == RS_RINGING) && (nxt == RS_TRIPPED);
  assign ev_release = (state == RS_RINGING) && (nxt != RS_RINGING);

  // R3: the relay only engages on a cycle where sync was seen high.
  a_r3_engage_on_sync: assert property (@(posedge clk) disable iff (rst)
    $fell(relay_n) |-> $past(sync_hi));

  // R4: a denial seen by the state machine leaves the relay released.
  a_r4_deny_releases: assert property (@(posedge clk) disable iff (rst)
    deny |=> relay_n);

  // R5 / R6: off hook always leaves the relay released.
  a_r6_offhook_releases: assert property (@(posedge clk) disable iff (rst)
    offhook |=> relay_n);

  // R6: a trip holds while the command stays active.
  a_r6_trip_holds: assert property (@(posedge clk) disable iff (rst)
    (state == RS_TRIPPED && cmd_act) |=> state == RS_TRIPPED);

  // R8: releases happen on sync high unless a veto forced them.
  a_r8_release_aligned: assert property (@(posedge clk) disable iff (rst)
    $rose(relay_n) |-> $past(sync_hi || deny || offhook));

  // R9: an armed line under veto goes back to idle, never to ringing.
  a_r9_veto_beats_sync: assert property (@(posedge clk) disable iff (rst)
    (state == RS_ARMED && (deny || offhook)) |=> state == RS_IDLE);

endmodule

// File: rtl/ring_relay_ctrl.sv
module ring_relay_ctrl
  import ring_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic ring_cmd_n,
  input  logic ring_sync,
  input  logic pwr_deny_n,
  input  logic hook_n,
  output logic relay_n
);

  localparam int NUM_IN = 4;
  // Bit layout: [3] hook_n, [2] pwr_deny_n, [1] ring_sync, [0] ring_cmd_n.
  localparam logic [NUM_IN-1:0] IN_IDLE = 4'b1101;

  logic [NUM_IN-1:0] raw_in;
  logic [NUM_IN-1:0] syn_in;

  logic cmd_act, sync_hi, deny, offhook, veto, start_ok, stop_ok;
  logic ev_engage, ev_trip, ev_release;
  ring_state_t state;

  assign raw_in = {hook_n, pwr_deny_n, ring_sync, ring_cmd_n};

  ring_sync_bank #(
    .WIDTH  (NUM_IN),
    .STAGES (SYNC_STAGES),
    .RST_VAL(IN_IDLE)
  ) u_sync (
    .clk    (clk),
    .rst    (rst),
    .d_async(raw_in),
    .q_sync (syn_in)
  );

  ring_qualify u_qual (
    .cmd_n_s (syn_in[0]),
    .sync_s  (syn_in[1]),
    .pd_n_s  (syn_in[2]),
    .hook_n_s(syn_in[3]),
    .cmd_act (cmd_act),
    .sync_hi (sync_hi),
    .deny    (deny),
    .offhook (offhook),
    .veto    (veto),
    .start_ok(start_ok),
    .stop_ok (stop_ok)
  );

  ring_fsm u_fsm (
    .clk       (clk),
    .rst       (rst),
    .cmd_act   (cmd_act),
    .sync_hi   (sync_hi),
    .deny      (deny),
    .offhook   (offhook),
    .start_ok  (start_ok),
    .stop_ok   (stop_ok),
    .state     (state),
    .relay_n   (relay_n),
    .ev_engage (ev_engage),
    .ev_trip   (ev_trip),
    .ev_release(ev_release)
  );

  // R1: reset leaves the relay released.
  a_r1_reset_released: assert property (@(posedge clk)
    rst |=> relay_n);

  // R5 / R9: an engage never happens under a veto.
  a_r5_no_engage_vetoed: assert property (@(posedge clk) disable iff (rst)
    ev_engage |-> !veto);

  // R6: a trip always follows an off-hook observation.
  a_r6_trip_cause: assert property (@(posedge clk) disable iff (rst)
    ev_trip |-> (offhook && ev_release));

endmodule

// File: tb/tb_ring_relay_ctrl.sv
module tb_ring_relay_ctrl;

  localparam int STG = 2;
  localparam int LAT = STG + 1;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic ring_cmd_n = 1'b1;
  logic ring_sync  = 1'b0;
  logic pwr_deny_n = 1'b1;
  logic hook_n     = 1'b1;
  logic relay_n;

  int checks = 0;
  int errors = 0;

  always #2.5 clk = ~clk;

  ring_relay_ctrl #(.SYNC_STAGES(STG)) dut (
    .clk       (clk),
    .rst       (rst),
    .ring_cmd_n(ring_cmd_n),
    .ring_sync (ring_sync),
    .pwr_deny_n(pwr_deny_n),
    .hook_n    (hook_n),
    .relay_n   (relay_n)
  );

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check(input logic exp, input string req, input string what);
    checks++;
    if (relay_n !== exp) begin
      errors++;
      $display("FAIL %s %s: relay_n=%b expected %b", req, what, relay_n, exp);
    end
  endtask

  task automatic do_reset();
    rst = 1'b1;
    step(3);
    rst = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: run did not end, expected completion");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    step(1);
    do_reset();
    check(1'b1, "R1", "after reset");

    // R2: command active, sync low, no engage
    ring_cmd_n = 1'b0;
    step(8);
    check(1'b1, "R2", "cmd with sync low");

    // R3: exact latency from sync rise
    ring_sync = 1'b1;
    step(LAT - 1);
    check(1'b1, "R3", "one edge before engage");
    step(1);
    check(1'b0, "R3", "engaged on sync");

    // R8: withdrawal waits for sync high
    ring_sync = 1'b0;
    step(4);
    ring_cmd_n = 1'b1;
    step(6);
    check(1'b0, "R8", "held while sync low");
    ring_sync = 1'b1;
    step(LAT - 1);
    check(1'b0, "R8", "one edge before release");
    step(1);
    check(1'b1, "R8", "released on sync");

    // R3 with sync tied high, then R6 ring trip
    ring_cmd_n = 1'b0;
    step(LAT);
    check(1'b0, "R3", "sync tied high acts at once");
    hook_n = 1'b0;
    step(LAT - 1);
    check(1'b0, "R6", "one edge before trip");
    step(1);
    check(1'b1, "R6", "tripped");
    hook_n = 1'b1;
    step(6);
    check(1'b1, "R6", "trip held after on-hook");

    // R7: withdraw clears trip
    ring_cmd_n = 1'b1;
    step(4);
    ring_cmd_n = 1'b0;
    step(LAT);
    check(1'b0, "R7", "rings again after withdraw");

    // R4: denial while ringing
    pwr_deny_n = 1'b0;
    step(LAT - 1);
    check(1'b0, "R4", "one edge before denial release");
    step(1);
    check(1'b1, "R4", "denial released");
    step(6);
    check(1'b1, "R4", "denial holds off");
    pwr_deny_n = 1'b1;
    step(LAT);
    check(1'b0, "R4", "resumes after denial lifted");

    // R5: off hook before command
    ring_cmd_n = 1'b1;
    step(4);
    hook_n = 1'b0;
    step(4);
    ring_cmd_n = 1'b0;
    step(8);
    check(1'b1, "R5", "no engage when off hook");

    // R9: off hook and sync rise in same cycle while armed
    hook_n = 1'b1;
    ring_cmd_n = 1'b1;
    ring_sync = 1'b0;
    step(4);
    ring_cmd_n = 1'b0;
    step(5);
    ring_sync = 1'b1;
    hook_n = 1'b0;
    for (int i = 0; i < 6; i++) begin
      step(1);
      check(1'b1, "R9", "off hook vs sync collision");
    end

    // R9: denial and sync rise in same cycle while armed
    hook_n = 1'b1;
    ring_cmd_n = 1'b1;
    ring_sync = 1'b0;
    step(4);
    ring_cmd_n = 1'b0;
    step(5);
    ring_sync = 1'b1;
    pwr_deny_n = 1'b0;
    for (int i = 0; i < 6; i++) begin
      step(1);
      check(1'b1, "R9", "denial vs sync collision");
    end
    pwr_deny_n = 1'b1;

    // Sweep of all static input patterns from reset (R2 R3 R4 R5)
    for (int v = 0; v < 16; v++) begin
      logic c_n, sy, pd_n, h_n, exp;
      string tag;
      c_n  = v[0];
      sy   = v[1];
      pd_n = v[2];
      h_n  = v[3];
      ring_cmd_n = c_n;
      ring_sync  = sy;
      pwr_deny_n = pd_n;
      hook_n     = h_n;
      do_reset();
      step(8);
      exp = ~(~c_n & sy & pd_n & h_n);
      if (c_n)        tag = "R1";
      else if (!pd_n) tag = "R4";
      else if (!h_n)  tag = "R5";
      else if (!sy)   tag = "R2";
      else            tag = "R3";
      check(exp, tag, $sformatf("static pattern %0d", v));
    end

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule